// File: doc/BRIEF.md
# Low-Resolution Raster Sync Generator

This block produces the timing skeleton for a reduced-resolution analog monitor picture. One pixel-rate clock drives two counters: a column position that runs through every clock of a scan line, and a line position that runs through every line of a frame. From these it decodes an active-low horizontal sync, an active-low vertical sync and an active-video flag. While the flag is high it also gives the pixel column and row inside the visible window.

Pixel and color logic elsewhere reads `x` and `y` to fetch picture data. It uses `active` to force the color outputs to zero during retrace. The length of each timing segment is a parameter. The defaults give a 128-column by 255-row picture: a 300-clock line and a 556-line frame, which is close to 60 Hz from a 10 MHz pixel clock. The monitor only keys on the falling edges of the sync pulses, so the porches can be resized freely.

Top module: `rasterSyncGen`

## Requirements
- R1: While `rst` is high at a clock edge, both positions return to 0. During reset and in the first cycle after it, `hsync_n` = 0, `vsync_n` = 0 and `active` = 0.
- R2: The column position counts 0 to 299 and wraps from 299 to 0, so every line lasts exactly 300 clocks.
- R3: `hsync_n` is 0 at column positions 0 to 19 (20 clocks) and 1 at all other columns.
- R4: Columns 127 to 254 are visible. There `x` equals column minus 127, runs 0 to 127, and rises by one each clock.
- R5: The line position advances only on the 299-to-0 column wrap. It counts 0 to 555 and wraps to 0, so a frame lasts 166800 clocks.
- R6: `vsync_n` is 0 for lines 0 to 2 and 1 otherwise. It changes only in the cycle where `hsync_n` falls.
- R7: Lines 165 to 419 are visible. There `y` equals line minus 165, runs 0 to 254, and is constant across a line.
- R8: `active` is 1 only when both the column and the line are visible. That gives 32640 active clocks per frame, and `active` is never 1 during either sync pulse.
- R9: Each frame holds exactly 556 `hsync_n` falling edges and exactly one `vsync_n` falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | High while the beam paints the visible window |
| x | output | 7 | Visible column index; meaningful only while `active` is 1 |
| y | output | 8 | Visible row index; meaningful only while `active` is 1 |

## Verification
Every output is decoded combinationally from the two position registers. Each result is therefore due in the same cycle the positions reach the point of interest. After reset is released, the position equals the number of rising edges since the release. The bench keeps its own count of those edges and samples on the falling edge after each step. Its expected values come from the position arithmetic in the requirements: column = count mod 300, line = count / 300 mod 556. Edge and active-cycle totals are collected over one whole frame, and the frame boundary is checked on the exact clock it falls.

// File: rtl/rasterPkg.sv
package rasterPkg;

  // Horizontal-side strobes handed from control to datapath each cycle
  typedef struct packed {
    logic lineWrap;   // last column of the line: the line position advances
    logic hSync;      // inside the horizontal sync segment
    logic hVisible;   // inside the horizontal visible segment
  } hStrobe_t;

endpackage

// File: rtl/rasterZone.sv
// Generic segment decoder: sync, back porch, visible, front porch in that order
module rasterZone #(
  parameter int SYNC  = 20,
  parameter int BACK  = 107,
  parameter int SHOW  = 128,
  parameter int FRONT = 45,
  parameter int CW    = 9,
  parameter int IW    = 7
) (
  input  logic [CW-1:0] pos,
  output logic          syncOn,
  output logic          showOn,
  output logic          lastPos,
  output logic [IW-1:0] idx
);
  localparam int SHOW_START = SYNC + BACK;
  localparam int SHOW_END   = SHOW_START + SHOW;
  localparam int TOTAL      = SHOW_END + FRONT;

  localparam logic [CW-1:0] SYNC_C  = CW'(SYNC);
  localparam logic [CW-1:0] START_C = CW'(SHOW_START);
  localparam logic [CW-1:0] END_C   = CW'(SHOW_END);
  localparam logic [CW-1:0] LAST_C  = CW'(TOTAL - 1);

  always_comb begin
    syncOn  = (pos < SYNC_C);
    showOn  = (pos >= START_C) && (pos < END_C);
    lastPos = (pos == LAST_C);
    idx     = IW'(pos - START_C);
  end
endmodule

// File: rtl/rasterCtrl.sv
// Control: column position counter and horizontal decode
module rasterCtrl
  import rasterPkg::*;
#(
  parameter int H_SYNC  = 20,
  parameter int H_BACK  = 107,
  parameter int H_SHOW  = 128,
  parameter int H_FRONT = 45,
  parameter int HCW     = 9,
  parameter int XW      = 7
) (
  input  logic          clk,
  input  logic          rst,
  output hStrobe_t      strb,
  output logic [XW-1:0] xIdx
);
  logic [HCW-1:0] hPos;
  logic           hSyncOn;
  logic           hShowOn;
  logic           hLast;

  rasterZone #(
    .SYNC(H_SYNC), .BACK(H_BACK), .SHOW(H_SHOW), .FRONT(H_FRONT),
    .CW(HCW), .IW(XW)
  ) uZone (
    .pos(hPos), .syncOn(hSyncOn), .showOn(hShowOn),
    .lastPos(hLast), .idx(xIdx)
  );

  always_ff @(posedge clk) begin
    if (rst)        hPos <= '0;
    else if (hLast) hPos <= '0;
    else            hPos <= hPos + 1'b1;
  end

  always_comb begin
    strb.lineWrap = hLast;
    strb.hSync    = hSyncOn;
    strb.hVisible = hShowOn;
  end
endmodule

// File: rtl/rasterPath.sv
// Datapath: line position counter, vertical decode and output combine
module rasterPath
  import rasterPkg::*;
#(
  parameter int V_SYNC  = 3,
  parameter int V_BACK  = 162,
  parameter int V_SHOW  = 255,
  parameter int V_FRONT = 136,
  parameter int VCW     = 10,
  parameter int XW      = 7,
  parameter int YW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  hStrobe_t      strb,
  input  logic [XW-1:0] xIdx,
  output logic          hsyncN,
  output logic          vsyncN,
  output logic          activeOut,
  output logic [XW-1:0] xOut,
  output logic [YW-1:0] yOut
);
  logic [VCW-1:0] vPos;
  logic           vSyncOn;
  logic           vShowOn;
  logic           vLast;

  rasterZone #(
    .SYNC(V_SYNC), .BACK(V_BACK), .SHOW(V_SHOW), .FRONT(V_FRONT),
    .CW(VCW), .IW(YW)
  ) uZone (
    .pos(vPos), .syncOn(vSyncOn), .showOn(vShowOn),
    .lastPos(vLast), .idx(yOut)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vPos <= '0;
    end else if (strb.lineWrap) begin
      if (vLast) vPos <= '0;
      else       vPos <= vPos + 1'b1;
    end
  end

  always_comb begin
    hsyncN    = ~strb.hSync;
    vsyncN    = ~vSyncOn;
    activeOut = strb.hVisible & vShowOn;
    xOut      = xIdx;
  end
endmodule

// File: rtl/rasterSyncGen.sv
// Top: thin wrapper joining control and datapath
module rasterSyncGen #(
  parameter int H_SYNC  = 20,
  parameter int H_BACK  = 107,
  parameter int H_SHOW  = 128,
  parameter int H_FRONT = 45,
  parameter int V_SYNC  = 3,
  parameter int V_BACK  = 162,
  parameter int V_SHOW  = 255,
  parameter int V_FRONT = 136,
  localparam int H_TOTAL = H_SYNC + H_BACK + H_SHOW + H_FRONT,
  localparam int V_TOTAL = V_SYNC + V_BACK + V_SHOW + V_FRONT,
  localparam int XW      = $clog2(H_SHOW),
  localparam int YW      = $clog2(V_SHOW)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          active,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y
);
  localparam int HCW = $clog2(H_TOTAL);
  localparam int VCW = $clog2(V_TOTAL);

  rasterPkg::hStrobe_t hStrb;
  logic [XW-1:0]       xIdx;

  rasterCtrl #(
    .H_SYNC(H_SYNC), .H_BACK(H_BACK), .H_SHOW(H_SHOW), .H_FRONT(H_FRONT),
    .HCW(HCW), .XW(XW)
  ) uCtrl (
    .clk(clk), .rst(rst), .strb(hStrb), .xIdx(xIdx)
  );

  rasterPath #(
    .V_SYNC(V_SYNC), .V_BACK(V_BACK), .V_SHOW(V_SHOW), .V_FRONT(V_FRONT),
    .VCW(VCW), .XW(XW), .YW(YW)
  ) uPath (
    .clk(clk), .rst(rst), .strb(hStrb), .xIdx(xIdx),
    .hsyncN(hsync_n), .vsyncN(vsync_n), .activeOut(active),
    .xOut(x), .yOut(y)
  );
endmodule

// File: rtl/rasterSyncGen_chk.sv
module rasterSyncGen_chk #(
  parameter int HS = 20,
  parameter int HA = 128,
  parameter int XW = 7,
  parameter int YW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          active,
  input logic [XW-1:0] x,
  input logic [YW-1:0] y
);
  logic        armed = 1'b0;
  logic [15:0] lowLen;

  always_ff @(posedge clk) begin
    armed <= !rst;
    if (rst || hsync_n) lowLen <= '0;
    else                lowLen <= lowLen + 1'b1;
  end

  // R1: outputs at their reset values in the cycle after a reset edge
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!hsync_n && !vsync_n && !active));

  // R3: each horizontal sync pulse lasts exactly HS clocks
  p_hsync_width_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(hsync_n) |-> (lowLen == 16'(HS)));

  // R4: column index steps by one inside the visible window
  p_x_step_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    (active && x != XW'(HA - 1)) |=> (active && x == $past(x) + 1'b1));

  // R4: visible window closes after the last column
  p_x_end_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    (active && x == XW'(HA - 1)) |=> !active);

  // R6: vertical sync moves only at the start of a line
  p_vsync_align_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(vsync_n) |-> $fell(hsync_n));

  // R7: row index constant along a visible line
  p_y_hold_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    (active && $past(active)) |-> (y == $past(y)));

  // R8: never visible during a sync pulse
  p_blank_in_sync_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    active |-> (hsync_n && vsync_n));
endmodule

bind rasterSyncGen rasterSyncGen_chk #(
  .HS(H_SYNC), .HA(H_SHOW), .XW(XW), .YW(YW)
) u_chk (
  .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .active(active), .x(x), .y(y)
);

// File: tb/sim_rasterSyncGen.sv
`timescale 1ns/1ps
module sim_rasterSyncGen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsync_n, vsync_n, active;
  logic [6:0] x;
  logic [7:0] y;

  int checks = 0;
  int failures = 0;
  int pos = 0;
  int hFalls = 0;
  int vFalls = 0;
  int actCount = 0;
  logic prevH = 1'b0;
  logic prevV = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  rasterSyncGen u0 (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .active(active), .x(x), .y(y)
  );

  // {cycle[17:0], hsync_n, vsync_n, active, x[6:0], y[7:0]}
  localparam int NV = 20;
  localparam logic [35:0] VEC [0:NV-1] = '{
    {18'd0,      1'b0, 1'b0, 1'b0, 7'd0,   8'd0},
    {18'd19,     1'b0, 1'b0, 1'b0, 7'd0,   8'd0},
    {18'd20,     1'b1, 1'b0, 1'b0, 7'd0,   8'd0},
    {18'd299,    1'b1, 1'b0, 1'b0, 7'd0,   8'd0},
    {18'd300,    1'b0, 1'b0, 1'b0, 7'd0,   8'd0},
    {18'd650,    1'b1, 1'b0, 1'b0, 7'd0,   8'd0},
    {18'd900,    1'b0, 1'b1, 1'b0, 7'd0,   8'd0},
    {18'd920,    1'b1, 1'b1, 1'b0, 7'd0,   8'd0},
    {18'd49400,  1'b1, 1'b1, 1'b0, 7'd0,   8'd0},
    {18'd49626,  1'b1, 1'b1, 1'b0, 7'd0,   8'd0},
    {18'd49627,  1'b1, 1'b1, 1'b1, 7'd0,   8'd0},
    {18'd49754,  1'b1, 1'b1, 1'b1, 7'd127, 8'd0},
    {18'd49755,  1'b1, 1'b1, 1'b0, 7'd0,   8'd0},
    {18'd89890,  1'b1, 1'b1, 1'b1, 7'd63,  8'd134},
    {18'd125827, 1'b1, 1'b1, 1'b1, 7'd0,   8'd254},
    {18'd125954, 1'b1, 1'b1, 1'b1, 7'd127, 8'd254},
    {18'd126127, 1'b1, 1'b1, 1'b0, 7'd0,   8'd0},
    {18'd166799, 1'b1, 1'b1, 1'b0, 7'd0,   8'd0},
    {18'd166800, 1'b0, 1'b0, 1'b0, 7'd0,   8'd0},
    {18'd166820, 1'b1, 1'b0, 1'b0, 7'd0,   8'd0}
  };

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s at pos %0d: actual=%0d expected=%0d", tag, pos, actual, expected);
    end
  endtask

  // One rising edge, then sample on the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    pos++;
    if (prevH && !hsync_n) hFalls++;
    if (prevV && !vsync_n) vFalls++;
    if (active && pos < 166800) actCount++;
    prevH = hsync_n;
    prevV = vsync_n;
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at pos %0d", pos);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while reset is held
    chk("R1 hsync_n in reset", int'(hsync_n), 0);
    chk("R1 vsync_n in reset", int'(vsync_n), 0);
    chk("R1 active in reset", int'(active), 0);
    rst = 1'b0;
    pos = 0;
    prevH = hsync_n;
    prevV = vsync_n;

    // Vector walk over one full frame
    for (int i = 0; i < NV; i++) begin
      int cyc;
      cyc = int'(VEC[i][35:18]);
      while (pos < cyc) step();
      chk("R3 hsync_n", int'(hsync_n), int'(VEC[i][17]));
      chk("R6 vsync_n", int'(vsync_n), int'(VEC[i][16]));
      chk("R8 active", int'(active), int'(VEC[i][15]));
      if (VEC[i][15]) begin
        chk("R4 x", int'(x), int'(VEC[i][14:8]));
        chk("R7 y", int'(y), int'(VEC[i][7:0]));
      end
      if (cyc == 300 || cyc == 166800)
        chk("R2 R5 wrap hsync_n", int'(hsync_n), 0);
      if (cyc == 166800) begin
        chk("R9 hsync falls per frame", hFalls, 556);
        chk("R9 vsync falls per frame", vFalls, 1);
        chk("R8 active clocks per frame", actCount, 32640);
      end
    end

    // R1: reset in the middle of a line
    while (pos < 166850) step();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 hsync_n after mid-line reset", int'(hsync_n), 0);
    chk("R1 vsync_n after mid-line reset", int'(vsync_n), 0);
    chk("R1 active after mid-line reset", int'(active), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    pos = 0;
    prevH = hsync_n;
    prevV = vsync_n;
    while (pos < 19) step();
    chk("R3 hsync_n low at column 19 after reset", int'(hsync_n), 0);
    step();
    chk("R3 hsync_n high at column 20 after reset", int'(hsync_n), 1);
    chk("R6 vsync_n low on line 0 after reset", int'(vsync_n), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule